// File: doc/BRIEF.md
# Transmit Jabber and Receive Watchdog Guard

This block keeps a network port from holding the medium for too long in either direction. On the transmit side it measures how long the transmitter has been continuously active. The measure is either a count of bytes sent or a count of elapsed time ticks. When the limit is reached, the block raises a cut-off that aborts the frame and stops the transmit process. It then keeps the channel blocked until a release condition is met. The release is either immediate, on host request, or follows a fixed hold-off interval whose length depends on the line speed.

On the receive side it counts received bytes while carrier is present. An over-long carrier is timed out and the receive path is blocked. The block lifts that block only after the line has stayed quiet for a programmable number of bit times. Either guard can be switched off. Each timeout also emits a one-cycle event pulse for the status logic of the surrounding MAC.

Time limits are counted in `tick` pulses, which are nominally 100 µs apart. The byte limits are counted in `byte_stb` pulses and the receive quiet window in `bit_stb` pulses.

Top module: `link_guard`

## Requirements
- R1: After reset, `tx_cut`, `rx_cut`, `jab_evt` and `wd_evt` are all 0.
- R2: With `jab_bytemode`=1, while `tx_active` stays high, the 2304th `byte_stb` raises `jab_evt` for one cycle and sets `tx_cut` in the same cycle (2304 lies in the 2048 to 2560 byte window).
- R3: With `jab_bytemode`=0, the transmit limit is counted in `tick` pulses: 300 ticks (30 ms) when `fast`=0 and 30 ticks (3 ms) when `fast`=1.
- R4: Dropping `tx_active` clears the transmit count, so bursts shorter than the limit never cause a timeout.
- R5: With `jab_host_rel`=1, `tx_cut` is cleared on the clock edge after it was set.
- R6: With `jab_host_rel`=0, `tx_cut` stays high for 4000 ticks (400 ms) when `fast`=0 and 400 ticks (40 ms) when `fast`=1, counted from the timeout, and then clears.
- R7: While `jab_dis`=1, no transmit timeout occurs, and any active `tx_cut` is cleared on the next edge.
- R8: With `wd_dis`=0, the 2304th `byte_stb` during one continuous `rx_carrier` raises `wd_evt` for one cycle and sets `rx_cut`. Carrier that drops before that count never times out.
- R9: Once `rx_cut` is set, it clears after 44 `bit_stb` pulses of low carrier when `wd_long_rel`=1, or after 20 pulses when it is 0. Any return of carrier restarts this quiet count.
- R10: While `wd_dis`=1, no receive timeout occurs, and any active `rx_cut` is cleared on the next edge.
- R11: `jab_evt` and `wd_evt` are never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fast | input | 1 | Line speed: 1 = 100 Mb/s, 0 = 10 Mb/s |
| tx_active | input | 1 | Transmitter is sending |
| rx_carrier | input | 1 | Receive carrier present |
| byte_stb | input | 1 | One pulse per byte on the line |
| bit_stb | input | 1 | One pulse per bit time |
| tick | input | 1 | Time base pulse (100 µs nominal) |
| jab_dis | input | 1 | Disable the transmit guard |
| jab_bytemode | input | 1 | 1 = byte-count limit, 0 = time limit |
| jab_host_rel | input | 1 | 1 = release transmit at once after a timeout |
| wd_dis | input | 1 | Disable the receive guard |
| wd_long_rel | input | 1 | 1 = long receive quiet window (44 bit times), 0 = short (20) |
| tx_cut | output | 1 | Transmit cut-off held |
| rx_cut | output | 1 | Receive cut-off held |
| jab_evt | output | 1 | One-cycle pulse on a transmit timeout |
| wd_evt | output | 1 | One-cycle pulse on a receive timeout |

## Verification
A wrong count or a wrong choice of limit shows up as an event pulse and a cut-off edge that arrive early or late. Because the bench compares every output on every cycle against a behavioural model, such an error is seen on the cycle of the misplaced edge. A release counter that starts from the wrong point, or that misses a carrier restart, shows up as `tx_cut` or `rx_cut` dropping on the wrong cycle. A disable that does not take effect shows up one cycle after the disable bit rises, because the cut-off is still high then.

// File: rtl/link_guard.sv
module link_guard #(
  parameter int JAB_BYTES   = 2304,
  parameter int JAB_T10     = 300,
  parameter int JAB_T100    = 30,
  parameter int REL_T10     = 4000,
  parameter int REL_T100    = 400,
  parameter int WD_BYTES    = 2304,
  parameter int QUIET_LONG  = 44,
  parameter int QUIET_SHORT = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast,
  input  logic tx_active,
  input  logic rx_carrier,
  input  logic byte_stb,
  input  logic bit_stb,
  input  logic tick,
  input  logic jab_dis,
  input  logic jab_bytemode,
  input  logic jab_host_rel,
  input  logic wd_dis,
  input  logic wd_long_rel,
  output logic tx_cut,
  output logic rx_cut,
  output logic jab_evt,
  output logic wd_evt
);
  localparam int JMAX = (JAB_BYTES > JAB_T10) ? ((JAB_BYTES > JAB_T100) ? JAB_BYTES : JAB_T100)
                                              : ((JAB_T10 > JAB_T100) ? JAB_T10 : JAB_T100);
  localparam int RMAX = (REL_T10 > REL_T100) ? REL_T10 : REL_T100;
  localparam int QMAX = (QUIET_LONG > QUIET_SHORT) ? QUIET_LONG : QUIET_SHORT;
  localparam int JW = $clog2(JMAX + 1);
  localparam int RW = $clog2(RMAX + 1);
  localparam int WW = $clog2(WD_BYTES + 1);
  localparam int QW = $clog2(QMAX + 1);

  logic [JW-1:0] jcnt, jlim;
  logic [RW-1:0] rcnt, rlim;
  logic [WW-1:0] wcnt;
  logic [QW-1:0] qcnt, qlim;
  logic jstb;

  assign jlim = jab_bytemode ? JW'(JAB_BYTES) : (fast ? JW'(JAB_T100) : JW'(JAB_T10));
  assign rlim = fast ? RW'(REL_T100) : RW'(REL_T10);
  assign qlim = wd_long_rel ? QW'(QUIET_LONG) : QW'(QUIET_SHORT);
  assign jstb = jab_bytemode ? byte_stb : tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_cut  <= 1'b0;
      jab_evt <= 1'b0;
      jcnt    <= '0;
      rcnt    <= '0;
    end else begin
      jab_evt <= 1'b0;
      if (jab_dis) begin
        tx_cut <= 1'b0;
        jcnt   <= '0;
        rcnt   <= '0;
      end else if (tx_cut) begin
        jcnt <= '0;
        if (jab_host_rel) begin
          tx_cut <= 1'b0;
          rcnt   <= '0;
        end else if (tick) begin
          if (rcnt >= rlim - 1'b1) begin
            tx_cut <= 1'b0;
            rcnt   <= '0;
          end else begin
            rcnt <= rcnt + 1'b1;
          end
        end
      end else if (!tx_active) begin
        jcnt <= '0;
      end else if (jstb) begin
        if (jcnt >= jlim - 1'b1) begin
          tx_cut  <= 1'b1;
          jab_evt <= 1'b1;
          jcnt    <= '0;
        end else begin
          jcnt <= jcnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_cut <= 1'b0;
      wd_evt <= 1'b0;
      wcnt   <= '0;
      qcnt   <= '0;
    end else begin
      wd_evt <= 1'b0;
      if (wd_dis) begin
        rx_cut <= 1'b0;
        wcnt   <= '0;
        qcnt   <= '0;
      end else if (rx_cut) begin
        wcnt <= '0;
        if (rx_carrier) begin
          qcnt <= '0;
        end else if (bit_stb) begin
          if (qcnt >= qlim - 1'b1) begin
            rx_cut <= 1'b0;
            qcnt   <= '0;
          end else begin
            qcnt <= qcnt + 1'b1;
          end
        end
      end else if (!rx_carrier) begin
        wcnt <= '0;
      end else if (byte_stb) begin
        if (wcnt >= WW'(WD_BYTES - 1)) begin
          rx_cut <= 1'b1;
          wd_evt <= 1'b1;
          wcnt   <= '0;
        end else begin
          wcnt <= wcnt + 1'b1;
        end
      end
    end
  end

  AST_JEVT_PULSE: assert property (@(posedge clk) disable iff (!rst_n) jab_evt |=> !jab_evt); // R11
  AST_WEVT_PULSE: assert property (@(posedge clk) disable iff (!rst_n) wd_evt |=> !wd_evt); // R11
  AST_JEVT_CUTS: assert property (@(posedge clk) disable iff (!rst_n) jab_evt |-> tx_cut); // R2
  AST_WEVT_CUTS: assert property (@(posedge clk) disable iff (!rst_n) wd_evt |-> rx_cut); // R8
  AST_HOST_REL: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cut && jab_host_rel && !jab_dis) |=> !tx_cut); // R5
  AST_JAB_OFF: assert property (@(posedge clk) disable iff (!rst_n) jab_dis |=> (!tx_cut && !jab_evt)); // R7
  AST_WD_OFF: assert property (@(posedge clk) disable iff (!rst_n) wd_dis |=> (!rx_cut && !wd_evt)); // R10
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cut && rx_carrier && !wd_dis) |=> rx_cut); // R9
endmodule

// File: tb/test_link_guard.sv
module test_link_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fast = 1'b0, tx_active = 1'b0, rx_carrier = 1'b0;
  logic byte_stb = 1'b0, bit_stb = 1'b0, tick = 1'b0;
  logic jab_dis = 1'b0, jab_bytemode = 1'b1, jab_host_rel = 1'b0;
  logic wd_dis = 1'b0, wd_long_rel = 1'b1;
  logic tx_cut, rx_cut, jab_evt, wd_evt;

  always #4 clk = ~clk;

  link_guard i_link_guard (
    .clk(clk), .rst_n(rst_n), .fast(fast), .tx_active(tx_active), .rx_carrier(rx_carrier),
    .byte_stb(byte_stb), .bit_stb(bit_stb), .tick(tick), .jab_dis(jab_dis),
    .jab_bytemode(jab_bytemode), .jab_host_rel(jab_host_rel), .wd_dis(wd_dis),
    .wd_long_rel(wd_long_rel), .tx_cut(tx_cut), .rx_cut(rx_cut), .jab_evt(jab_evt), .wd_evt(wd_evt)
  );

  int compared = 0, mismatched = 0;
  string phase = "R1";
  int cyc = 0;
  int m_j = 0, m_r = 0, m_w = 0, m_q = 0;
  bit m_tc = 0, m_rc = 0, m_je = 0, m_we = 0;
  int jev_n = 0, wev_n = 0, jrun = 0, wrun = 0, max_run = 0;
  bit done = 0;

  always @(negedge clk) begin
    cyc++;
    bit_stb  = (cyc % 2 == 1);
    byte_stb = (cyc % 3 == 0);
    tick     = (cyc % 4 == 0);
  end

  always @(posedge clk) begin
    int jl, rl, ql;
    m_je = 0; m_we = 0;
    if (!rst_n) begin
      m_j = 0; m_r = 0; m_w = 0; m_q = 0; m_tc = 0; m_rc = 0;
    end else begin
      jl = jab_bytemode ? 2304 : (fast ? 30 : 300);
      rl = fast ? 400 : 4000;
      ql = wd_long_rel ? 44 : 20;
      if (jab_dis) begin m_tc = 0; m_j = 0; m_r = 0; end
      else if (m_tc) begin
        m_j = 0;
        if (jab_host_rel) begin m_tc = 0; m_r = 0; end
        else if (tick) begin m_r++; if (m_r >= rl) begin m_tc = 0; m_r = 0; end end
      end else if (!tx_active) m_j = 0;
      else if (jab_bytemode ? byte_stb : tick) begin
        m_j++;
        if (m_j >= jl) begin m_tc = 1; m_je = 1; m_j = 0; end
      end
      if (wd_dis) begin m_rc = 0; m_w = 0; m_q = 0; end
      else if (m_rc) begin
        m_w = 0;
        if (rx_carrier) m_q = 0;
        else if (bit_stb) begin m_q++; if (m_q >= ql) begin m_rc = 0; m_q = 0; end end
      end else if (!rx_carrier) m_w = 0;
      else if (byte_stb) begin
        m_w++;
        if (m_w >= 2304) begin m_rc = 1; m_we = 1; m_w = 0; end
      end
    end
  end

  task automatic cmp(input string what, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0b expected=%0b at cycle %0d", phase, what, act, exp, cyc);
    end
  endtask

  task automatic check_int(input string tag, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      cmp("tx_cut", tx_cut, m_tc);
      cmp("rx_cut", rx_cut, m_rc);
      cmp("jab_evt", jab_evt, m_je);
      cmp("wd_evt", wd_evt, m_we);
      if (jab_evt === 1'b1) begin jev_n++; jrun++; end else jrun = 0;
      if (wd_evt === 1'b1) begin wev_n++; wrun++; end else wrun = 0;
      if (jrun > max_run) max_run = jrun;
      if (wrun > max_run) max_run = wrun;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    phase = "R1";
    check_int("R1", "outputs after reset", {tx_cut, rx_cut, jab_evt, wd_evt}, 0);

    phase = "R2"; jev_n = 0; jab_bytemode = 1; jab_host_rel = 1; tx_active = 1;
    wait_cyc(7000);
    tx_active = 0; wait_cyc(5);
    check_int("R2", "byte-mode timeouts", jev_n, 1);
    check_int("R5", "tx_cut after host release", tx_cut, 0);

    phase = "R4"; jev_n = 0;
    for (int k = 0; k < 4; k++) begin
      tx_active = 1; wait_cyc(1500); tx_active = 0; wait_cyc(10);
    end
    check_int("R4", "timeouts on short bursts", jev_n, 0);

    phase = "R3"; jev_n = 0; jab_bytemode = 0; jab_host_rel = 0; fast = 0; tx_active = 1;
    wait_cyc(1300); tx_active = 0;
    check_int("R3", "slow time-mode timeouts", jev_n, 1);
    phase = "R6";
    wait_cyc(14000);
    check_int("R6", "tx_cut held during slow hold-off", tx_cut, 1);
    wait_cyc(3000);
    check_int("R6", "tx_cut after slow hold-off", tx_cut, 0);

    phase = "R3"; jev_n = 0; fast = 1; tx_active = 1;
    wait_cyc(130); tx_active = 0;
    check_int("R3", "fast time-mode timeouts", jev_n, 1);
    phase = "R6";
    wait_cyc(1000);
    check_int("R6", "tx_cut held during fast hold-off", tx_cut, 1);
    wait_cyc(1000);
    check_int("R6", "tx_cut after fast hold-off", tx_cut, 0);

    phase = "R7"; tx_active = 1;
    wait_cyc(200);
    check_int("R7", "tx_cut before disable", tx_cut, 1);
    jab_dis = 1; jev_n = 0;
    wait_cyc(1);
    check_int("R7", "tx_cut one cycle after disable", tx_cut, 0);
    wait_cyc(500);
    check_int("R7", "timeouts while disabled", jev_n, 0);
    tx_active = 0; jab_dis = 0; fast = 0;

    phase = "R8"; wev_n = 0;
    for (int k = 0; k < 3; k++) begin
      rx_carrier = 1; wait_cyc(2000); rx_carrier = 0; wait_cyc(20);
    end
    check_int("R8", "timeouts on short carrier", wev_n, 0);
    rx_carrier = 1; wait_cyc(7000);
    check_int("R8", "long carrier timeouts", wev_n, 1);
    check_int("R8", "rx_cut during long carrier", rx_cut, 1);

    phase = "R9"; wd_long_rel = 1; rx_carrier = 0;
    wait_cyc(60);
    check_int("R9", "rx_cut inside long quiet window", rx_cut, 1);
    rx_carrier = 1; wait_cyc(4); rx_carrier = 0;
    wait_cyc(60);
    check_int("R9", "rx_cut after carrier restart", rx_cut, 1);
    wait_cyc(60);
    check_int("R9", "rx_cut after long quiet window", rx_cut, 0);

    wev_n = 0; rx_carrier = 1; wait_cyc(7000);
    wd_long_rel = 0; rx_carrier = 0;
    wait_cyc(20);
    check_int("R9", "rx_cut inside short quiet window", rx_cut, 1);
    wait_cyc(40);
    check_int("R9", "rx_cut after short quiet window", rx_cut, 0);

    phase = "R10"; rx_carrier = 1; wait_cyc(7000);
    check_int("R10", "rx_cut before disable", rx_cut, 1);
    wd_dis = 1; wev_n = 0;
    wait_cyc(1);
    check_int("R10", "rx_cut one cycle after disable", rx_cut, 0);
    wait_cyc(7000);
    check_int("R10", "timeouts while disabled", wev_n, 0);
    rx_carrier = 0; wd_dis = 0;
    wait_cyc(5);

    check_int("R11", "longest event pulse", max_run, 1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    wait_cyc(150000);
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule